// File: doc/BRIEF.md
# Toggle-Bit Status Evaluator for Interleaved NOR Flash

This block works out what an embedded program or erase operation on a NOR flash is doing when the host has no status register to read. After a start pulse it reads one address several times through a simple request/data handshake. It then compares the returned words bit by bit and reports one of five outcomes: ready, busy, suspended, timeout or write-buffer abort.

The data word may carry several flash devices side by side. Each device occupies its own lane of `LANE_W` bits, and there are `N_DEV` lanes. A lane-enable mask selects which devices take part in the decision. The first phase makes three reads and looks for a toggling bit 6. If bit 6 toggles on some lane, the error bits in the first read decide the outcome. An error is reported only when every toggling lane shows it. If bit 6 toggles on no lane, two more reads follow, and bit 2 tells an idle device from a suspended one.

Issuing reset commands, timing retries and producing the flash bus timing are left to the surrounding host logic.

Top module: `toggle_status_eval`

## Requirements
- R1: While reset is asserted and after it is released, `done` and `rd_req` are 0 and `result` is 0 (ready).
- R2: The address on `status_addr` is captured when `start` is accepted. Every read of that evaluation presents the captured value on `rd_addr`. A `start` that arrives while an evaluation is running is ignored.
- R3: Lane d's bit 6 (data bit d*LANE_W+6) toggles only if it differs between read 1 and read 2 and also between read 2 and read 3. If any enabled lane toggles, the evaluation ends after exactly three reads. With no error qualified, the result is busy (code 1).
- R4: When bit 6 toggles and `wbuf_mode` was high at start, the result is write-buffer abort (code 4) if bit 1 of read 1 is set on every toggling lane. When `wbuf_mode` was low, bit 1 has no effect.
- R5: When bit 6 toggles and abort is not reported, the result is timeout (code 3) if bit 5 of read 1 is set on every toggling lane. If a toggling lane has bit 5 clear, the result is busy.
- R6: Abort takes precedence over timeout when the conditions for both hold.
- R7: If bit 6 toggles on no enabled lane, exactly five reads are made in total. If bit 2 is equal in reads 4 and 5 on every enabled lane, the result is ready (code 0). Bit 6 in reads 4 and 5 has no effect.
- R8: In the second phase, the result is suspended (code 2) when bit 2 differs between reads 4 and 5 on every enabled lane. It is busy when only some enabled lanes differ.
- R9: Lanes whose `lane_en` bit was 0 at start take no part in any decision.
- R10: `done` is high for exactly one cycle per evaluation. `result` is valid in that cycle and stays unchanged until the next evaluation ends.
- R11: `rd_req` stays high until `rd_valid` returns a word. It is low in the cycle after each captured word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches an evaluation |
| wbuf_mode | input | 1 | Operation being polled is a write-buffer program; captured at start |
| lane_en | input | N_DEV | Device lanes taking part; captured at start |
| status_addr | input | ADDR_W | Address to poll; captured at start |
| rd_req | output | 1 | Read request, held until answered |
| rd_addr | output | ADDR_W | Address of the requested read |
| rd_valid | input | 1 | One-cycle pulse: `rd_data` carries the read word |
| rd_data | input | N_DEV*LANE_W | Returned data word, all lanes |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ready, 1 busy, 2 suspended, 3 timeout, 4 write-buffer abort |

## Verification
Read sequences are chosen so that each one separates a pair of outcomes. Bit 6 changing only between reads 1 and 2 tells a true toggle from a single glitch. Error bits set on one toggling lane but not the other tell per-lane qualification from a simple OR. Abort and timeout bits set together, with the write-buffer flag on and then off, show the precedence rule. Second-phase words with bit 2 changing on all, some or only disabled lanes separate suspended, busy and ready. Read counts and addresses are checked for each run, with varied answer latency and a `start` injected mid-run.

// File: rtl/tse_pkg.sv
package tse_pkg;

    typedef enum logic [2:0] {
        ST_READY      = 3'd0,
        ST_BUSY       = 3'd1,
        ST_SUSPENDED  = 3'd2,
        ST_TIMEOUT    = 3'd3,
        ST_WBUF_ABORT = 3'd4
    } status_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_READ,
        PH_STEP,
        PH_DONE
    } phase_e;

    localparam int TOG_BIT     = 6;
    localparam int ERR_BIT     = 5;
    localparam int SUSP_BIT    = 2;
    localparam int ABORT_BIT   = 1;
    localparam int READS_FIRST = 3;
    localparam int READS_ALL   = 5;

    function automatic int lane_pos(int dev, int bitn, int lane_w);
        return dev * lane_w + bitn;
    endfunction

endpackage

// File: rtl/tse_lane_judge.sv
module tse_lane_judge
    import tse_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int N_DEV  = 2,
    localparam int DATA_W = LANE_W * N_DEV
) (
    input  logic [READS_ALL-1:0][DATA_W-1:0] words,
    input  logic [N_DEV-1:0]                 en,
    input  logic                             wbuf,
    output logic                             any_tog6,
    output status_e                          first_res,
    output status_e                          second_res
);

    logic [N_DEV-1:0] tog6;
    logic [N_DEV-1:0] abort_ok;
    logic [N_DEV-1:0] tmo_ok;
    logic [N_DEV-1:0] tog2;

    // One comparator set per device lane
    for (genvar d = 0; d < N_DEV; d++) begin : g_lane
        localparam int P6 = lane_pos(d, TOG_BIT, LANE_W);
        localparam int P5 = lane_pos(d, ERR_BIT, LANE_W);
        localparam int P2 = lane_pos(d, SUSP_BIT, LANE_W);
        localparam int P1 = lane_pos(d, ABORT_BIT, LANE_W);

        assign tog6[d]     = en[d] & (words[0][P6] ^ words[1][P6])
                                   & (words[1][P6] ^ words[2][P6]);
        assign abort_ok[d] = ~tog6[d] | words[0][P1];
        assign tmo_ok[d]   = ~tog6[d] | words[0][P5];
        assign tog2[d]     = en[d] & (words[3][P2] ^ words[4][P2]);
    end

    assign any_tog6 = |tog6;

    always_comb begin
        if (wbuf && (&abort_ok)) begin
            first_res = ST_WBUF_ABORT;
        end else if (&tmo_ok) begin
            first_res = ST_TIMEOUT;
        end else begin
            first_res = ST_BUSY;
        end

        if (tog2 == '0) begin
            second_res = ST_READY;
        end else if (tog2 == en) begin
            second_res = ST_SUSPENDED;
        end else begin
            second_res = ST_BUSY;
        end
    end

endmodule

// File: rtl/tse_read_seq.sv
module tse_read_seq
    import tse_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int N_DEV  = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             start,
    input  logic [ADDR_W-1:0]                addr_in,
    input  logic [N_DEV-1:0]                 en_in,
    input  logic                             wbuf_in,
    input  logic                             rd_valid,
    input  logic [DATA_W-1:0]                rd_data,
    input  logic                             any_tog6,
    input  status_e                          first_res,
    input  status_e                          second_res,
    output logic                             rd_req,
    output logic [ADDR_W-1:0]                rd_addr,
    output logic                             done,
    output status_e                          result,
    output logic [READS_ALL-1:0][DATA_W-1:0] words,
    output logic [N_DEV-1:0]                 en_q,
    output logic                             wbuf_q
);

    localparam logic [2:0] CNT_FIRST = 3'(READS_FIRST);
    localparam logic [2:0] CNT_ALL   = 3'(READS_ALL);

    phase_e      state;
    logic [2:0]  cnt;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PH_IDLE;
            cnt    <= '0;
            addr_q <= '0;
            en_q   <= '0;
            wbuf_q <= 1'b0;
            result <= ST_READY;
            words  <= '0;
        end else begin
            unique case (state)
                PH_IDLE: if (start) begin
                    addr_q <= addr_in;
                    en_q   <= en_in;
                    wbuf_q <= wbuf_in;
                    cnt    <= '0;
                    state  <= PH_READ;
                end
                PH_READ: if (rd_valid) begin
                    words[cnt] <= rd_data;
                    cnt        <= cnt + 3'd1;
                    state      <= PH_STEP;
                end
                PH_STEP: begin
                    if (cnt == CNT_FIRST && any_tog6) begin
                        result <= first_res;
                        state  <= PH_DONE;
                    end else if (cnt == CNT_ALL) begin
                        result <= second_res;
                        state  <= PH_DONE;
                    end else begin
                        state  <= PH_READ;
                    end
                end
                PH_DONE: state <= PH_IDLE;
                default: state <= PH_IDLE;
            endcase
        end
    end

    assign rd_req  = (state == PH_READ);
    assign rd_addr = addr_q;
    assign done    = (state == PH_DONE);

    logic busy;
    assign busy = (state != PH_IDLE);

    a_r11_req_drop: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_valid) |=> !rd_req);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(rd_addr));

    a_r7_read_total: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt == CNT_FIRST || cnt == CNT_ALL));

    a_r3_short_run: assert property (@(posedge clk) disable iff (rst)
        (done && cnt == CNT_FIRST) |-> (result != ST_READY && result != ST_SUSPENDED));

    a_r8_susp_long: assert property (@(posedge clk) disable iff (rst)
        (done && result == ST_SUSPENDED) |-> cnt == CNT_ALL);

endmodule

// File: rtl/toggle_status_eval.sv
module toggle_status_eval
    import tse_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int N_DEV  = 2,
    parameter int ADDR_W = 24,
    localparam int DATA_W = LANE_W * N_DEV
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wbuf_mode,
    input  logic [N_DEV-1:0]  lane_en,
    input  logic [ADDR_W-1:0] status_addr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic [2:0]        result
);

    logic [READS_ALL-1:0][DATA_W-1:0] words;
    logic [N_DEV-1:0] en_q;
    logic             wbuf_q;
    logic             any_tog6;
    status_e          first_res;
    status_e          second_res;
    status_e          res_s;

    tse_read_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .N_DEV  (N_DEV)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .addr_in    (status_addr),
        .en_in      (lane_en),
        .wbuf_in    (wbuf_mode),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .any_tog6   (any_tog6),
        .first_res  (first_res),
        .second_res (second_res),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .done       (done),
        .result     (res_s),
        .words      (words),
        .en_q       (en_q),
        .wbuf_q     (wbuf_q)
    );

    tse_lane_judge #(
        .LANE_W (LANE_W),
        .N_DEV  (N_DEV)
    ) u_judge (
        .words      (words),
        .en         (en_q),
        .wbuf       (wbuf_q),
        .any_tog6   (any_tog6),
        .first_res  (first_res),
        .second_res (second_res)
    );

    assign result = res_s;

    a_r4_abort_needs_flag: assert property (@(posedge clk) disable iff (rst)
        (done && res_s == ST_WBUF_ABORT) |-> wbuf_q);

    a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(done)) |-> $stable(result));

endmodule

// File: tb/toggle_status_eval_test.sv
module toggle_status_eval_test;

    localparam int LANE_W = 8;
    localparam int N_DEV  = 2;
    localparam int ADDR_W = 24;
    localparam int DATA_W = LANE_W * N_DEV;
    localparam int NVEC   = 13;

    typedef struct packed {
        logic [1:0]  en;
        logic        wbuf;
        logic [15:0] w0;
        logic [15:0] w1;
        logic [15:0] w2;
        logic [15:0] w3;
        logic [15:0] w4;
        logic [2:0]  exp;
        logic [2:0]  nrd;
    } vec_t;

    // lane0 = bits 7:0, lane1 = bits 15:8; codes 0 ready,1 busy,2 susp,3 tmo,4 abort
    localparam vec_t VECS [NVEC] = '{
        '{2'b11, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 3'd0, 3'd5},
        '{2'b11, 1'b0, 16'h0040, 16'h0000, 16'h0040, 16'h0000, 16'h0000, 3'd1, 3'd3},
        '{2'b11, 1'b0, 16'h0060, 16'h0020, 16'h0060, 16'h0000, 16'h0000, 3'd3, 3'd3},
        '{2'b11, 1'b1, 16'h0062, 16'h0022, 16'h0062, 16'h0000, 16'h0000, 3'd4, 3'd3},
        '{2'b11, 1'b0, 16'h0062, 16'h0022, 16'h0062, 16'h0000, 16'h0000, 3'd3, 3'd3},
        '{2'b11, 1'b1, 16'h4042, 16'h0000, 16'h4040, 16'h0000, 16'h0000, 3'd1, 3'd3},
        '{2'b11, 1'b0, 16'h6060, 16'h0000, 16'h4040, 16'h0000, 16'h0000, 3'd3, 3'd3},
        '{2'b11, 1'b0, 16'h0040, 16'h0000, 16'h0000, 16'h0004, 16'h0000, 3'd1, 3'd5},
        '{2'b11, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0404, 16'h0000, 3'd2, 3'd5},
        '{2'b01, 1'b0, 16'h4000, 16'h0000, 16'h4000, 16'h0004, 16'h0000, 3'd2, 3'd5},
        '{2'b01, 1'b0, 16'h0060, 16'h0020, 16'h0060, 16'h0000, 16'h0000, 3'd3, 3'd3},
        '{2'b10, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0004, 16'h0000, 3'd0, 3'd5},
        '{2'b11, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h4040, 16'h0000, 3'd0, 3'd5}
    };

    function automatic string vec_tag(int i);
        case (i)
            0:  return "R7 idle";
            1:  return "R3 busy";
            2:  return "R5 timeout";
            3:  return "R6 abort over timeout";
            4:  return "R4 flag off";
            5:  return "R4 partial abort";
            6:  return "R5 both lanes";
            7:  return "R8 partial suspend / R3 glitch";
            8:  return "R8 suspended";
            9:  return "R9 disabled lane toggle";
            10: return "R9 timeout one lane";
            11: return "R9 disabled bit2";
            default: return "R7 bit6 late";
        endcase
    endfunction

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic              wbuf_mode;
    logic [N_DEV-1:0]  lane_en;
    logic [ADDR_W-1:0] status_addr;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              done;
    logic [2:0]        result;

    int checks = 0;
    int errors = 0;

    logic [DATA_W-1:0] mem [5];
    int                reads_seen = 0;
    int                resp_delay = 0;
    int                wait_ctr   = 0;
    logic [ADDR_W-1:0] exp_addr   = '0;

    always #5 clk = ~clk;

    toggle_status_eval #(
        .LANE_W (LANE_W),
        .N_DEV  (N_DEV),
        .ADDR_W (ADDR_W)
    ) uut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .wbuf_mode   (wbuf_mode),
        .lane_en     (lane_en),
        .status_addr (status_addr),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .done        (done),
        .result      (result)
    );

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Read responder: answers after resp_delay extra cycles
    initial begin
        rd_valid = 1'b0;
        rd_data  = '0;
        forever begin
            @(negedge clk);
            if (rd_valid) begin
                check(!rd_req, "R11 req low after capture", rd_req, 0);
                rd_valid = 1'b0;
            end else if (rd_req) begin
                if (wait_ctr < resp_delay) begin
                    wait_ctr++;
                end else begin
                    wait_ctr = 0;
                    check(rd_addr == exp_addr, "R2 read address", rd_addr, exp_addr);
                    rd_data  = mem[reads_seen < 5 ? reads_seen : 4];
                    reads_seen++;
                    rd_valid = 1'b1;
                end
            end else if (wait_ctr != 0) begin
                check(1'b0, "R11 req dropped before answer", 0, 1);
                wait_ctr = 0;
            end
        end
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic load(vec_t v);
        mem[0] = v.w0; mem[1] = v.w1; mem[2] = v.w2; mem[3] = v.w3; mem[4] = v.w4;
        reads_seen = 0;
    endtask

    task automatic wait_done(string tag, output bit ok);
        int cyc = 0;
        while (!done && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
        ok = done;
        if (!done) check(1'b0, {tag, " watchdog"}, 0, 1);
    endtask

    task automatic run_vec(vec_t v, string tag, logic [ADDR_W-1:0] a, int dly);
        bit ok;
        logic [2:0] r;
        load(v);
        resp_delay = dly;
        exp_addr   = a;
        @(negedge clk);
        start = 1'b1; status_addr = a; lane_en = v.en; wbuf_mode = v.wbuf;
        @(negedge clk);
        start = 1'b0; status_addr = ~a; lane_en = ~v.en; wbuf_mode = ~v.wbuf;
        wait_done(tag, ok);
        if (ok) begin
            check(result == v.exp, {tag, " result"}, result, v.exp);
            check(reads_seen == int'(v.nrd), {tag, " R7 read count"}, reads_seen, v.nrd);
            r = result;
            @(negedge clk);
            check(!done, "R10 done one cycle", done, 0);
            check(result == r, "R10 result held", result, r);
        end
    endtask

    initial begin
        bit ok;
        rst = 1'b1; start = 1'b0; wbuf_mode = 1'b0; lane_en = '0; status_addr = '0;
        repeat (3) @(negedge clk);
        check(!done && !rd_req && result == 3'd0, "R1 during reset",
              {done, rd_req, result}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !rd_req && result == 3'd0, "R1 after reset",
              {done, rd_req, result}, 0);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i], vec_tag(i), 24'h100000 + 24'(i * 24'h1234), i % 3);
        end

        // R2: start during a running evaluation is ignored
        load(VECS[8]);
        resp_delay = 2;
        exp_addr   = 24'hABCDE0;
        @(negedge clk);
        start = 1'b1; status_addr = 24'hABCDE0; lane_en = 2'b11; wbuf_mode = 1'b0;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1; status_addr = 24'h111110; lane_en = 2'b01; wbuf_mode = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R2 mid-run start", ok);
        if (ok) begin
            check(result == 3'd2, "R2 mid-run start result", result, 2);
            check(reads_seen == 5, "R2 mid-run start reads", reads_seen, 5);
        end
        repeat (4) @(negedge clk);
        check(!rd_req && !done, "R2 no queued run", {rd_req, done}, 0);

        // R10: result unchanged while idle
        repeat (5) @(negedge clk);
        check(result == 3'd2, "R10 result held while idle", result, 2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule